// File: doc/BRIEF.md
# Tiled-Render Bin Loop Sequencer

This block lives inside a command processor and runs a loop over screen bins. It watches the stream of 32-bit command words. When it sees the packet that opens a bin loop, it takes the five payload words: the bin count, a 64-bit base address for the per-bin prefix buffers, the prefix size and the body size. It then runs the loop through its fetch request port.

Each iteration has two steps. First comes a nested (second-level) fetch of that bin's prefix, whose address steps forward by one prefix length per bin. Then comes a rewind of the first-level fetch pointer to the start of the body. The body is the run of words that follows the packet and ends with the end-of-loop marker. The body therefore never has to be unrolled in memory. Every body word that is not the marker is consumed without effect, so nested indirect calls inside the body are left to the rest of the command processor.

After the last bin, the block asks for fetching to resume just past the marker and becomes idle again. Addresses are byte addresses. Sizes are counted in 32-bit words.

Top module: `binloop_seq`

## Requirements
- R1: In the idle state, a word with `cmd_hdr`=1 and `cmd_data[7:0]`=0x50 opens a loop. Any other word accepted while idle is consumed with no effect: no request is issued and `busy` stays 0.
- R2: The five words accepted after the opening header are taken in order as the bin count, the low and then the high half of the prefix base, the prefix size in words and the body size in words. The body start is the byte address of the last of these words plus 4.
- R3: For bin i, a request with address base + 4·i·prefix_words, length prefix_words and level 2 (nested) is issued before that bin's body request.
- R4: After each prefix request is accepted, a request with the body-start address, length body_words and level 1 (first level) is issued.
- R5: During the body, a header word with `cmd_data[7:0]`=0x51 ends the current iteration. All other body words, including a second 0x50 header, are consumed and do not restart the loop.
- R6: The loop runs exactly bin-count iterations. After the last 0x51 marker, one request is issued with address body_start + 4·body_words, length 0 and level 1.
- R7: A bin count of 0 produces only the resume request of R6, with no prefix or body request.
- R8: All address sums use full 64-bit arithmetic, so a carry crosses from the low word into the high word.
- R9: `bin_valid` is 1 and `bin_index` equals i from the prefix request of bin i until the marker that ends bin i. `bin_valid` is 0 outside the loop.
- R10: `busy` is 1 from the cycle after the opening header is accepted until the resume request is accepted. `cmd_ready` is 0 while a request is pending.
- R11: While `req_valid`=1 and `req_ready`=0, the request stays asserted with unchanged address, length and level.
- R12: After reset, `busy`, `req_valid` and `bin_valid` are 0 and `cmd_ready` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid | input | 1 | Command word offered |
| cmd_ready | output | 1 | Block can take a command word |
| cmd_hdr | input | 1 | Offered word is a packet header |
| cmd_data | input | 32 | Command word |
| cmd_addr | input | 64 | Byte address the word was fetched from |
| req_valid | output | 1 | Fetch request offered |
| req_ready | input | 1 | Fetch request taken |
| req_addr | output | 64 | Fetch byte address |
| req_dwords | output | 32 | Fetch length in words (0 = open-ended resume) |
| req_level | output | 2 | 1 = first-level stream, 2 = nested buffer |
| bin_valid | output | 1 | A bin iteration is in progress |
| bin_index | output | 32 | Current bin number |
| busy | output | 1 | A loop is in progress |

## Verification
The hardest state to reach is a later iteration whose prefix address has carried into the upper address word while the loop is held under fetch backpressure. To reach it, the bench places the base a few bytes below a 4 GiB boundary and holds `req_ready` low for several cycles on every request. After each rewind, it replays the body words as a real fetcher would, and it puts a stray 0x50 header inside one body to show that the loop is not restarted.

// File: rtl/binloop_pkg.sv
package binloop_pkg;

    localparam int ADDR_W  = 64;
    localparam int WORD_W  = 32;
    localparam int OPC_LSB = 0;
    localparam int OPC_W   = 8;
    localparam int LVL_W   = 2;

    localparam logic [OPC_W-1:0] OPC_LOOP_OPEN  = 8'h50;
    localparam logic [OPC_W-1:0] OPC_LOOP_CLOSE = 8'h51;

    localparam int PAYLOAD_WORDS = 5;
    localparam int SLOT_W        = $clog2(PAYLOAD_WORDS);
    localparam int BYTES_PER_WORD = WORD_W / 8;
    localparam int WORD_SHIFT     = $clog2(BYTES_PER_WORD);

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_CAPT,
        ST_DECIDE,
        ST_PREFIX,
        ST_REWIND,
        ST_BODY,
        ST_RESUME
    } seq_state_e;

    typedef enum logic [SLOT_W-1:0] {
        SL_COUNT   = 3'd0,
        SL_BASE_LO = 3'd1,
        SL_BASE_HI = 3'd2,
        SL_PFX     = 3'd3,
        SL_BODY    = 3'd4
    } pl_slot_e;

    typedef enum logic [LVL_W-1:0] {
        LVL_NONE   = 2'd0,
        LVL_MAIN   = 2'd1,
        LVL_NESTED = 2'd2
    } fetch_lvl_e;

    typedef struct packed {
        logic [ADDR_W-1:0] addr;
        logic [WORD_W-1:0] dwords;
        fetch_lvl_e        lvl;
    } fetch_req_t;

    typedef struct packed {
        logic [WORD_W-1:0] bin_cnt;
        logic [ADDR_W-1:0] base;
        logic [WORD_W-1:0] pfx_dw;
        logic [WORD_W-1:0] body_dw;
        logic [ADDR_W-1:0] body_start;
    } loop_params_t;

    function automatic logic [ADDR_W-1:0] words_to_bytes(input logic [WORD_W-1:0] n);
        logic [ADDR_W-1:0] wide;
        wide = {{(ADDR_W-WORD_W){1'b0}}, n};
        return wide << WORD_SHIFT;
    endfunction

    function automatic logic opc_is(input logic hdr,
                                    input logic [OPC_W-1:0] opc,
                                    input logic [OPC_W-1:0] want);
        return hdr && (opc == want);
    endfunction

endpackage

// File: rtl/binloop_capture.sv
module binloop_capture
    import binloop_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic                take,
    input  pl_slot_e            slot,
    input  logic [WORD_W-1:0]   data,
    input  logic [ADDR_W-1:0]   word_addr,
    output loop_params_t        prm
);
    localparam int HALF_W = ADDR_W / 2;

    always_ff @(posedge clk) begin
        if (rst) begin
            prm <= '0;
        end else if (take) begin
            case (slot)
                SL_COUNT:   prm.bin_cnt <= data;
                SL_BASE_LO: prm.base[HALF_W-1:0] <= data;
                SL_BASE_HI: prm.base[ADDR_W-1:HALF_W] <= data;
                SL_PFX:     prm.pfx_dw <= data;
                SL_BODY: begin
                    prm.body_dw    <= data;
                    prm.body_start <= word_addr + ADDR_W'(BYTES_PER_WORD);
                end
                default: ;
            endcase
        end
    end

endmodule

// File: rtl/binloop_addr.sv
module binloop_addr
    import binloop_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic                load,
    input  logic                step,
    input  logic [ADDR_W-1:0]   base,
    input  logic [WORD_W-1:0]   pfx_dw,
    input  logic [ADDR_W-1:0]   body_start,
    input  logic [WORD_W-1:0]   body_dw,
    output logic [ADDR_W-1:0]   pfx_addr,
    output logic [ADDR_W-1:0]   resume_addr
);
    logic [ADDR_W-1:0] pfx_stride;

    assign pfx_stride  = words_to_bytes(pfx_dw);
    assign resume_addr = body_start + words_to_bytes(body_dw);

    always_ff @(posedge clk) begin
        if (rst) begin
            pfx_addr <= '0;
        end else if (load) begin
            pfx_addr <= base;
        end else if (step) begin
            pfx_addr <= pfx_addr + pfx_stride;
        end
    end

    // R8: stepping never moves the prefix pointer backwards unless the sum wraps 64 bits
    p_step_forward_r8: assert property (@(posedge clk) disable iff (rst)
        (step && !load && (pfx_dw != '0) && (pfx_addr < ~pfx_stride))
            |=> (pfx_addr > $past(pfx_addr)));

endmodule

// File: rtl/binloop_ctrl.sv
module binloop_ctrl
    import binloop_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic                cmd_valid,
    input  logic                cmd_hdr,
    input  logic [OPC_W-1:0]    cmd_opc,
    output logic                cmd_ready,
    input  logic [WORD_W-1:0]   bin_cnt,
    input  logic [WORD_W-1:0]   pfx_dw,
    input  logic [WORD_W-1:0]   body_dw,
    input  logic [ADDR_W-1:0]   body_start,
    input  logic [ADDR_W-1:0]   pfx_addr,
    input  logic [ADDR_W-1:0]   resume_addr,
    output logic                take,
    output pl_slot_e            slot,
    output logic                load,
    output logic                step,
    output logic                req_valid,
    input  logic                req_ready,
    output fetch_req_t          req,
    output logic                bin_valid,
    output logic [WORD_W-1:0]   bin_idx,
    output logic                busy
);
    seq_state_e state, state_nx;
    logic       acc, is_open, is_close, last_bin;

    assign cmd_ready = (state == ST_IDLE) || (state == ST_CAPT) || (state == ST_BODY);
    assign acc       = cmd_valid && cmd_ready;
    assign is_open   = opc_is(cmd_hdr, cmd_opc, OPC_LOOP_OPEN);
    assign is_close  = opc_is(cmd_hdr, cmd_opc, OPC_LOOP_CLOSE);
    assign take      = acc && (state == ST_CAPT);
    assign last_bin  = (bin_idx + WORD_W'(1)) == bin_cnt;
    assign busy      = (state != ST_IDLE);
    assign bin_valid = (state == ST_PREFIX) || (state == ST_REWIND) || (state == ST_BODY);
    assign load      = (state == ST_DECIDE);
    assign step      = (state == ST_BODY) && acc && is_close && !last_bin;

    always_comb begin
        req_valid = 1'b0;
        req       = '{addr: '0, dwords: '0, lvl: LVL_NONE};
        case (state)
            ST_PREFIX: begin
                req_valid = 1'b1;
                req       = '{addr: pfx_addr, dwords: pfx_dw, lvl: LVL_NESTED};
            end
            ST_REWIND: begin
                req_valid = 1'b1;
                req       = '{addr: body_start, dwords: body_dw, lvl: LVL_MAIN};
            end
            ST_RESUME: begin
                req_valid = 1'b1;
                req       = '{addr: resume_addr, dwords: '0, lvl: LVL_MAIN};
            end
            default: ;
        endcase
    end

    always_comb begin
        state_nx = state;
        case (state)
            ST_IDLE:   if (acc && is_open) state_nx = ST_CAPT;
            ST_CAPT:   if (take && slot == SL_BODY) state_nx = ST_DECIDE;
            ST_DECIDE: state_nx = (bin_cnt == '0) ? ST_RESUME : ST_PREFIX;
            ST_PREFIX: if (req_ready) state_nx = ST_REWIND;
            ST_REWIND: if (req_ready) state_nx = ST_BODY;
            ST_BODY:   if (acc && is_close) state_nx = last_bin ? ST_RESUME : ST_PREFIX;
            ST_RESUME: if (req_ready) state_nx = ST_IDLE;
            default:   state_nx = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state   <= ST_IDLE;
            slot    <= SL_COUNT;
            bin_idx <= '0;
        end else begin
            state <= state_nx;
            if (state == ST_IDLE) begin
                slot <= SL_COUNT;
            end else if (take && slot != SL_BODY) begin
                slot <= pl_slot_e'(slot + SLOT_W'(1));
            end
            if (state == ST_DECIDE) begin
                bin_idx <= '0;
            end else if (step) begin
                bin_idx <= bin_idx + WORD_W'(1);
            end
        end
    end

    // R11: a pending request is held unchanged under backpressure
    p_req_hold_r11: assert property (@(posedge clk) disable iff (rst)
        (req_valid && !req_ready) |=> (req_valid && $stable(req)));

    // R10: no command word is taken while a fetch request is pending
    p_cmd_blocked_r10: assert property (@(posedge clk) disable iff (rst)
        req_valid |-> !cmd_ready);

    // R9: the bin index stays below the captured count while a bin runs
    p_bin_range_r9: assert property (@(posedge clk) disable iff (rst)
        bin_valid |-> (bin_idx < bin_cnt));

    // R12: an idle sequencer offers nothing
    p_idle_quiet_r12: assert property (@(posedge clk) disable iff (rst)
        !busy |-> (!req_valid && !bin_valid));

    // R3: nested fetches only happen inside a bin iteration
    p_nested_in_bin_r3: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req.lvl == LVL_NESTED) |-> bin_valid);

    // R1: an accepted opening header makes the block busy next cycle
    p_open_busy_r1: assert property (@(posedge clk) disable iff (rst)
        (!busy && acc && is_open) |=> busy);

    // R7: a zero count goes straight to the resume request
    p_zero_skip_r7: assert property (@(posedge clk) disable iff (rst)
        (state == ST_DECIDE && bin_cnt == '0) |=> (req_valid && !bin_valid));

endmodule

// File: rtl/binloop_seq.sv
module binloop_seq
    import binloop_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 cmd_valid,
    output logic                 cmd_ready,
    input  logic                 cmd_hdr,
    input  logic [31:0]          cmd_data,
    input  logic [63:0]          cmd_addr,
    output logic                 req_valid,
    input  logic                 req_ready,
    output logic [63:0]          req_addr,
    output logic [31:0]          req_dwords,
    output logic [1:0]           req_level,
    output logic                 bin_valid,
    output logic [31:0]          bin_index,
    output logic                 busy
);
    loop_params_t      prm;
    fetch_req_t        req;
    pl_slot_e          slot;
    logic              take, load, step;
    logic [ADDR_W-1:0] pfx_addr, resume_addr;

    binloop_capture u_capture (
        .clk       (clk),
        .rst       (rst),
        .take      (take),
        .slot      (slot),
        .data      (cmd_data),
        .word_addr (cmd_addr),
        .prm       (prm)
    );

    binloop_addr u_addr (
        .clk         (clk),
        .rst         (rst),
        .load        (load),
        .step        (step),
        .base        (prm.base),
        .pfx_dw      (prm.pfx_dw),
        .body_start  (prm.body_start),
        .body_dw     (prm.body_dw),
        .pfx_addr    (pfx_addr),
        .resume_addr (resume_addr)
    );

    binloop_ctrl u_ctrl (
        .clk         (clk),
        .rst         (rst),
        .cmd_valid   (cmd_valid),
        .cmd_hdr     (cmd_hdr),
        .cmd_opc     (cmd_data[OPC_LSB +: OPC_W]),
        .cmd_ready   (cmd_ready),
        .bin_cnt     (prm.bin_cnt),
        .pfx_dw      (prm.pfx_dw),
        .body_dw     (prm.body_dw),
        .body_start  (prm.body_start),
        .pfx_addr    (pfx_addr),
        .resume_addr (resume_addr),
        .take        (take),
        .slot        (slot),
        .load        (load),
        .step        (step),
        .req_valid   (req_valid),
        .req_ready   (req_ready),
        .req         (req),
        .bin_valid   (bin_valid),
        .bin_idx     (bin_index),
        .busy        (busy)
    );

    assign req_addr   = req.addr;
    assign req_dwords = req.dwords;
    assign req_level  = req.lvl;

endmodule

// File: tb/sim_binloop_seq.sv
module sim_binloop_seq;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cmd_valid = 1'b0;
    logic        cmd_ready;
    logic        cmd_hdr = 1'b0;
    logic [31:0] cmd_data = '0;
    logic [63:0] cmd_addr = '0;
    logic        req_valid;
    logic        req_ready = 1'b0;
    logic [63:0] req_addr;
    logic [31:0] req_dwords;
    logic [1:0]  req_level;
    logic        bin_valid;
    logic [31:0] bin_index;
    logic        busy;

    int n_chk = 0;
    int n_fail = 0;
    int cyc = 0;
    bit finished = 0;

    always #10 clk = ~clk;

    binloop_seq u0 (
        .clk(clk), .rst(rst),
        .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_hdr(cmd_hdr),
        .cmd_data(cmd_data), .cmd_addr(cmd_addr),
        .req_valid(req_valid), .req_ready(req_ready), .req_addr(req_addr),
        .req_dwords(req_dwords), .req_level(req_level),
        .bin_valid(bin_valid), .bin_index(bin_index), .busy(busy)
    );

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    endtask

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 150000 && !finished) begin
            finished = 1;
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual cycle %0d expected < 150000", cyc);
            summary();
        end
    end

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
        end
    endtask

    task automatic send_word(input logic hdr, input logic [31:0] d, input logic [63:0] a);
        @(negedge clk);
        cmd_valid = 1'b1; cmd_hdr = hdr; cmd_data = d; cmd_addr = a;
        while (!cmd_ready) @(negedge clk);
        @(negedge clk);
        cmd_valid = 1'b0; cmd_hdr = 1'b0;
    endtask

    // Wait for a request, hold it off, check it stays, then accept it.
    task automatic take_req(input string tag, input logic [63:0] ea,
                            input logic [31:0] el, input logic [1:0] ev,
                            input logic bv, input logic [31:0] bi);
        @(negedge clk);
        while (!req_valid) @(negedge clk);
        chk({tag, " addr"}, req_addr, ea);
        chk({tag, " len"}, {32'b0, req_dwords}, {32'b0, el});
        chk({tag, " level"}, {62'b0, req_level}, {62'b0, ev});
        chk({tag, " R10 cmd_ready low"}, {63'b0, cmd_ready}, 64'd0);
        chk({tag, " R9 bin_valid"}, {63'b0, bin_valid}, {63'b0, bv});
        if (bv) chk({tag, " R9 bin_index"}, {32'b0, bin_index}, {32'b0, bi});
        repeat (3) @(negedge clk);
        chk({tag, " R11 held valid"}, {63'b0, req_valid}, 64'd1);
        chk({tag, " R11 held addr"}, req_addr, ea);
        req_ready = 1'b1;
        @(negedge clk);
        req_ready = 1'b0;
    endtask

    task automatic run_loop(input string name, input logic [63:0] h,
                            input logic [31:0] cnt, input logic [63:0] base,
                            input logic [31:0] pfx, input logic [31:0] nbody,
                            input bit stray_open);
        logic [63:0] bstart;
        bstart = h + 64'd24;
        send_word(1'b1, 32'h0000_0050, h);
        chk({name, " R10 busy after open"}, {63'b0, busy}, 64'd1);
        send_word(1'b0, cnt, h + 4);
        send_word(1'b0, base[31:0], h + 8);
        send_word(1'b0, base[63:32], h + 12);
        send_word(1'b0, pfx, h + 16);
        send_word(1'b0, nbody, h + 20);
        for (int i = 0; i < cnt; i++) begin
            take_req({name, " R3 R8 prefix"},
                     base + 64'(i) * 64'(pfx) * 64'd4, pfx, 2'd2, 1'b1, 32'(i));
            take_req({name, " R4 rewind"}, bstart, nbody, 2'd1, 1'b1, 32'(i));
            for (int k = 0; k < nbody - 1; k++) begin
                if (stray_open && k == 0)
                    send_word(1'b1, 32'h0000_0050, bstart + 64'(4 * k));
                else
                    send_word(k[0], 32'hAB00_0000 | 32'(k), bstart + 64'(4 * k));
            end
            chk({name, " R5 still in bin"}, {32'b0, bin_index}, {32'b0, 32'(i)});
            send_word(1'b1, 32'h0000_0051, bstart + 64'(4 * (nbody - 1)));
        end
        take_req({name, " R6 R7 resume"}, bstart + 64'(nbody) * 64'd4, 32'd0, 2'd1, 1'b0, 32'd0);
        @(negedge clk);
        chk({name, " R10 idle after resume"}, {63'b0, busy}, 64'd0);
        chk({name, " R9 bin_valid idle"}, {63'b0, bin_valid}, 64'd0);
    endtask

    task automatic t_reset();
        chk("R12 busy", {63'b0, busy}, 64'd0);
        chk("R12 req_valid", {63'b0, req_valid}, 64'd0);
        chk("R12 bin_valid", {63'b0, bin_valid}, 64'd0);
        chk("R12 cmd_ready", {63'b0, cmd_ready}, 64'd1);
    endtask

    task automatic t_idle_noise();
        send_word(1'b1, 32'h0000_0051, 64'h100);
        send_word(1'b0, 32'h0000_0050, 64'h104);
        send_word(1'b1, 32'h1234_0046, 64'h108);
        repeat (3) @(negedge clk);
        chk("R1 noise busy", {63'b0, busy}, 64'd0);
        chk("R1 noise req", {63'b0, req_valid}, 64'd0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_idle_noise();
        run_loop("basic R2", 64'h0000_0000_0000_1000, 32'd3,
                 64'h0000_0002_0000_4000, 32'd6, 32'd4, 1'b0);
        run_loop("stray R5", 64'h0000_0000_0000_2000, 32'd2,
                 64'h0000_0000_0000_8000, 32'd3, 32'd3, 1'b1);
        run_loop("zero R7", 64'h0000_0000_0000_3000, 32'd0,
                 64'h0000_0000_0000_9000, 32'd5, 32'd7, 1'b0);
        run_loop("carry R8", 64'h0000_0001_FFFF_FFE0, 32'd3,
                 64'h0000_0000_FFFF_FFF0, 32'd8, 32'd2, 1'b0);
        run_loop("single R6", 64'h0000_0000_0000_5000, 32'd1,
                 64'h0000_0000_0000_A000, 32'd1, 32'd1, 1'b0);
        finished = 1;
        summary();
    end

endmodule